// File: doc/BRIEF.md
# Sequential shift-add multiplier

This block multiplies two unsigned operands over several clock cycles with a single operand-width adder. A one-cycle `start` while the unit is idle captures the multiplicand and the multiplier. The multiplier goes into the lower half of a double-width accumulator, and the upper half of that accumulator is cleared. No separate multiplier register exists.

On each iteration the accumulator's lowest bit decides the addend. When that bit is 1, the multiplicand is added to the upper half. When it is 0, zero is added. The sum, including its carry, then moves into the top of the accumulator as the whole accumulator shifts right by one bit. The multiplier bits leave at the bottom as product bits enter from the top.

After exactly one iteration per operand bit (32 by default), the unit raises `done_o` for a single cycle. The full product sits on the upper and lower result words. The lower word alone is the truncated integer product. The result stays on the outputs until the next accepted start.

Top module: `seq_shift_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `busy_o` and `done_o` are 0 and both result words are 0.
- R2: A `start` that is sampled high while `busy_o` is 0 is accepted. `busy_o` is 1 from the next cycle on.
- R3: An accepted start is followed by exactly OP_W cycles with `busy_o` high. `done_o` is then 1 for exactly one cycle, which is the first cycle in which `busy_o` is 0 again.
- R4: While `done_o` is 1, the value {`prod_hi_o`,`prod_lo_o`} equals the unsigned 2*OP_W-bit product of the captured operands. `prod_hi_o` holds the upper OP_W bits and `prod_lo_o` the lower OP_W bits.
- R5: While `busy_o` is 1, `start` and any change on the operand inputs have no effect: the result and the completion time of the current operation stay the same, and no extra completion occurs.
- R6: The adder's carry out is kept, so all-ones times all-ones yields 0xFFFFFFFE_00000001 with OP_W=32.
- R7: A zero operand yields a zero product. An operand of 1 yields the other operand in the lower word and zero in the upper word.
- R8: While `busy_o` is 0 and no start is accepted, both result words hold their value.
- R9: A start that arrives in the same cycle as `done_o` is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply |
| mcand_i | input | OP_W | Multiplicand operand |
| mplier_i | input | OP_W | Multiplier operand |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| prod_hi_o | output | OP_W | Upper half of the product |
| prod_lo_o | output | OP_W | Lower half of the product |

## Verification
The bench targets the carry case (all ones times all ones). A design that dropped the adder's carry would return a wrong upper word there.

It also targets a stream of start pulses and operand changes during busy. A design that did not ignore them would restart, corrupt the result, or produce an extra completion.

Zero and one operands, and back-to-back starts in the done cycle, check the clearing of the upper half and the acceptance rule. An off-by-one iteration count shows up as both a wrong busy length and a product that is shifted by one bit.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } mul_state_t;

   localparam int ADDER_BEHAV  = 0;
   localparam int ADDER_RIPPLE = 1;
endpackage

// File: rtl/mul_adder.sv
module mul_adder #(
   parameter int W    = 32,
   parameter int KIND = 0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W:0]   sum_o
);
   generate
      if (KIND == mulseq_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
            assign cy[i+1]  = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
         end
         assign sum_o[W] = cy[W];
      end else begin : g_behav
         assign sum_o = {1'b0, a_i} + {1'b0, b_i};
      end
   endgenerate
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
   parameter int OP_W = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load_o,
   output logic step_o,
   output logic busy_o,
   output logic done_o
);
   import mulseq_pkg::*;

   localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W - 1);

   mul_state_t       state_q;
   logic [CNT_W-1:0] iter_q;
   logic             done_q;

   assign load_o = start && (state_q == ST_IDLE);
   assign step_o = (state_q == ST_RUN);
   assign busy_o = (state_q == ST_RUN);
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         iter_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_RUN;
                  iter_q  <= '0;
               end
            end
            default: begin
               if (iter_q == LAST) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
               iter_q <= iter_q + 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
   parameter int OP_W       = 32,
   parameter int ADDER_KIND = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [OP_W-1:0]   mcand_i,
   input  logic [OP_W-1:0]   mplier_i,
   output logic [2*OP_W-1:0] acc_o
);
   localparam int PROD_W = 2 * OP_W;

   logic [OP_W-1:0]   mcand_q;
   logic [PROD_W-1:0] acc_q;
   logic [OP_W-1:0]   addend;
   logic [OP_W:0]     sum;

   assign addend = acc_q[0] ? mcand_q : '0;

   mul_adder #(.W(OP_W), .KIND(ADDER_KIND)) u_add (
      .a_i  (acc_q[PROD_W-1:OP_W]),
      .b_i  (addend),
      .sum_o(sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcand_q <= '0;
         acc_q   <= '0;
      end else if (load_i) begin
         mcand_q <= mcand_i;
         acc_q   <= {{OP_W{1'b0}}, mplier_i};
      end else if (step_i) begin
         acc_q <= {sum, acc_q[OP_W-1:1]};
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/seq_shift_mul.sv
module seq_shift_mul #(
   parameter int OP_W       = 32,
   parameter int ADDER_KIND = mulseq_pkg::ADDER_BEHAV
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [OP_W-1:0] mcand_i,
   input  logic [OP_W-1:0] mplier_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [OP_W-1:0] prod_hi_o,
   output logic [OP_W-1:0] prod_lo_o
);
   localparam int PROD_W = 2 * OP_W;

   generate
      if (OP_W < 2) begin : g_bad_width
         $error("seq_shift_mul: OP_W must be at least 2");
      end
      if (ADDER_KIND != mulseq_pkg::ADDER_BEHAV &&
          ADDER_KIND != mulseq_pkg::ADDER_RIPPLE) begin : g_bad_kind
         $error("seq_shift_mul: unknown ADDER_KIND");
      end
   endgenerate

   logic              load, step;
   logic [PROD_W-1:0] acc;

   mul_ctrl #(.OP_W(OP_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load_o(load),
      .step_o(step),
      .busy_o(busy_o),
      .done_o(done_o)
   );

   mul_datapath #(.OP_W(OP_W), .ADDER_KIND(ADDER_KIND)) u_dp (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .step_i  (step),
      .mcand_i (mcand_i),
      .mplier_i(mplier_i),
      .acc_o   (acc)
   );

   assign prod_hi_o = acc[PROD_W-1:OP_W];
   assign prod_lo_o = acc[OP_W-1:0];
endmodule

// File: rtl/seq_shift_mul_chk.sv
module seq_shift_mul_chk #(
   parameter int OP_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic [OP_W-1:0] mcand_i,
   input logic [OP_W-1:0] mplier_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [OP_W-1:0] prod_hi_o,
   input logic [OP_W-1:0] prod_lo_o
);
   localparam int PROD_W = 2 * OP_W;

   logic [OP_W-1:0] a_q, b_q;
   logic [31:0]     run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         run_len <= '0;
      end else begin
         if (start && !busy_o) begin
            a_q <= mcand_i;
            b_q <= mplier_i;
         end
         run_len <= busy_o ? run_len + 1 : 32'd0;
      end
   end

   always_comb begin
      if (!rst_n) begin
         a_reset_r1: assert (!busy_o && !done_o && prod_hi_o == '0 && prod_lo_o == '0);
      end
   end

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_o) |=> busy_o);

   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_run_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_len == OP_W));

   p_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ({prod_hi_o, prod_lo_o} ==
                  ({{OP_W{1'b0}}, a_q} * {{OP_W{1'b0}}, b_q})));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start) |=> ($stable(prod_hi_o) && $stable(prod_lo_o)));

   p_no_early_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && run_len < OP_W - 1) |=> !done_o);

   logic [PROD_W-1:0] unused_w;
   assign unused_w = '0;
endmodule

bind seq_shift_mul seq_shift_mul_chk #(.OP_W(OP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .mcand_i  (mcand_i),
   .mplier_i (mplier_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .prod_hi_o(prod_hi_o),
   .prod_lo_o(prod_lo_o)
);

// File: tb/seq_shift_mul_test.sv
module seq_shift_mul_test;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] mcand = '0, mplier = '0;
   logic         busy, done;
   logic [W-1:0] hi, lo;

   int total = 0;
   int bad = 0;
   logic [2*W-1:0] exp_q[$];
   logic [2*W-1:0] last_res = '0;
   int busy_cnt = 0;
   int seen = 0;

   always #10 clk = ~clk;

   seq_shift_mul #(.OP_W(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .mcand_i(mcand), .mplier_i(mplier),
      .busy_o(busy), .done_o(done),
      .prod_hi_o(hi), .prod_lo_o(lo)
   );

   task automatic check64(string req, logic [2*W-1:0] act, logic [2*W-1:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Monitor: pops the scoreboard on each completion, checks busy length (R3)
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_cnt++;
         if (done) begin
            seen++;
            check64("R3 busy cycles", 64'(busy_cnt), 64'(W));
            check64("R3 busy low at done", 64'(busy), 64'd0);
            if (exp_q.size() == 0) begin
               check64("R5 unexpected completion", 64'd1, 64'd0);
            end else begin
               last_res = exp_q.pop_front();
               check64("R4/R6/R7 product", {hi, lo}, last_res);
            end
            busy_cnt = 0;
         end
      end
   end

   task automatic run_op(logic [W-1:0] a, logic [W-1:0] b);
      while (busy) @(negedge clk);
      mcand  = a;
      mplier = b;
      start  = 1'b1;
      exp_q.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
      @(negedge clk);
      start = 1'b0;
      total++;
      if (!busy) begin
         bad++;
         $display("FAIL R2 busy actual=%0b expected=1", busy);
      end
   endtask

   // R5: start pulses and operand changes while busy
   task automatic run_noisy(logic [W-1:0] a, logic [W-1:0] b);
      run_op(a, b);
      for (int k = 0; k < 10; k++) begin
         mcand  = $urandom;
         mplier = $urandom;
         start  = k[0];
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy || exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check64("R1 reset outputs", {30'd0, busy, done, hi}, 64'd0);
      check64("R1 reset lo", 64'(lo), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check64("R1 after reset", {30'd0, busy, done, hi}, 64'd0);

      // R7 corners
      run_op(32'd0, 32'h1234_5678);
      run_op(32'hDEAD_BEEF, 32'd0);
      run_op(32'd1, 32'hCAFE_F00D);
      run_op(32'h8765_4321, 32'd1);
      // R6 carry case
      run_op('1, '1);
      wait_idle();
      check64("R6 all ones", {hi, lo}, 64'hFFFF_FFFE_0000_0001);
      run_op(32'h8000_0000, 32'h8000_0000);
      run_op('1, 32'd2);

      // R5 noise while busy
      run_noisy(32'h0F0F_0F0F, 32'hF0F0_F0F0);
      wait_idle();
      check64("R5 single completion count", 64'(seen), 64'd8);

      // R9 back to back plus random values
      for (int i = 0; i < 20; i++) run_op($urandom, $urandom);
      wait_idle();

      // R8 hold while idle
      mcand = $urandom;
      mplier = $urandom;
      repeat (5) @(negedge clk);
      check64("R8 hold", {hi, lo}, last_res);
      check64("R9 completion count", 64'(seen), 64'd28);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule